// File: doc/BRIEF.md
# Parallel-Prefix Carry-Lookahead Adder

This block adds two WIDTH-bit operands and a carry-in and returns the WIDTH-bit sum and the carry-out. Each bit position forms a generate term (both operand bits set) and a propagate term (either operand bit set). A recursive prefix network then merges these pairs with an associative carry operator. The operator combines a higher pair (gh, ph) with a lower pair (gl, pl) into (gh | (ph & gl), ph & pl). Combining the pair of bit i with the merged pair of all lower bits yields the carry into bit i+1.

The carry-in is folded into bit 0 by a single seed cell. The network therefore spans exactly WIDTH elements, and its element i gives the carry into bit i+1. The top network uses the minimum-depth variant, which takes log2(WIDTH) operator levels. That variant splits its inputs in half. It runs the minimum-depth variant on the upper half and the reduced-size variant on the lower half. It then merges the lower half's last result into every upper-half output. The reduced-size variant works in three steps. It first merges adjacent pairs, then runs the minimum-depth variant on the pair results, and finally fixes up the even positions with one more level of cells.

The parameter OUT_REG selects the output stage. When it is 1, the result is held in a register with an asynchronous active-low reset. When it is 0, the result is purely combinational. WIDTH must be a power of two between 4 and 64; any other value stops elaboration with an error.

Top module: `lf_adder`

## Requirements
- R1: With OUT_REG=1, {cout, sum} seen after rising edge k equals a + b + cin as sampled at edge k, taken modulo 2^(WIDTH+1).
- R2: cout is bit WIDTH of the full sum a + b + cin (sum occupies bits WIDTH-1..0).
- R3: The generate term of a bit is a AND b and its propagate term is a OR b. Each sum bit uses the separate half-sum (a XOR b) XOR carry, so a = b = all ones with cin = 0 gives sum = all ones shifted left by one and cout = 1.
- R4: The carry into every bit i+1 equals g(i) OR (p(i) AND carry into bit i), with the carry into bit 0 equal to cin.
- R5: The propagate part of network element i equals the AND of propagate terms 0..i. For example, a = 0101..01, b = 1010..10, cin = 1 propagates through all bits and gives sum = 0, cout = 1.
- R6: While rst_n is low, the registered sum and cout are 0 whatever the operands.
- R7: All ones plus one with cin = 0 gives sum = 0 and cout = 1.
- R8: a = 0, b = 0, cin = 1 gives sum = 1 and cout = 0.
- R9: With OUT_REG=0, {cout, sum} equals a + b + cin in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| cout | output | 1 | Carry out of the top bit |

## Verification
In the registered instance, a result appears one rising edge after its operands. The bench drives operands on a falling edge and queues the expected value. It checks that value at the next falling edge, once the capturing rising edge has passed. In the combinational instance, the result is due within the same cycle. That instance is checked one nanosecond after its operands change, before the next edge.

// File: rtl/lf_pkg.sv
package lf_pkg;

    // True when w is a power of two inside the supported range
    function automatic bit width_ok(input int w);
        return (w >= 4) && (w <= 64) && ((w & (w - 1)) == 0);
    endfunction

    // Number of operator levels of the minimum-depth network
    function automatic int levels(input int w);
        int n;
        n = 0;
        while ((1 << n) < w) n++;
        return n;
    endfunction

endpackage

// File: rtl/lf_cell.sv
module lf_cell (
    input  logic hi_g,
    input  logic hi_p,
    input  logic lo_g,
    input  logic lo_p,
    output logic g,
    output logic p
);
    // One application of the associative carry operator
    assign g = hi_g | (hi_p & lo_g);
    assign p = hi_p & lo_p;
endmodule

// File: rtl/lf_pg.sv
module lf_pg #(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] gen,
    output logic [WIDTH-1:0] prp,
    output logic [WIDTH-1:0] hsum
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign gen[i]  = a[i] & b[i];
        assign prp[i]  = a[i] | b[i];
        assign hsum[i] = a[i] ^ b[i];
    end
endmodule

// File: rtl/lf_prefix.sv
module lf_prefix #(
    parameter int N = 4,
    parameter int K = 0
) (
    input  logic [N-1:0] gi,
    input  logic [N-1:0] pi,
    output logic [N-1:0] go,
    output logic [N-1:0] po
);
    localparam int H = (N > 1) ? N / 2 : 1;

    if (N == 1) begin : g_wire
        assign go = gi;
        assign po = pi;
    end else if (N == 2) begin : g_two
        assign go[0] = gi[0];
        assign po[0] = pi[0];
        lf_cell u_top (
            .hi_g(gi[1]), .hi_p(pi[1]),
            .lo_g(gi[0]), .lo_p(pi[0]),
            .g(go[1]),    .p(po[1])
        );
    end else if (K == 0 || N == 4) begin : g_split
        // Minimum-depth form: reduced-size lower half, minimum-depth upper half
        logic [H-1:0] lg, lp, ug, up;

        lf_prefix #(.N(H), .K(1)) u_lo (
            .gi(gi[H-1:0]), .pi(pi[H-1:0]), .go(lg), .po(lp)
        );
        lf_prefix #(.N(H), .K(0)) u_hi (
            .gi(gi[N-1:H]), .pi(pi[N-1:H]), .go(ug), .po(up)
        );

        assign go[H-1:0] = lg;
        assign po[H-1:0] = lp;

        for (genvar j = 0; j < H; j++) begin : g_merge
            lf_cell u_m (
                .hi_g(ug[j]),   .hi_p(up[j]),
                .lo_g(lg[H-1]), .lo_p(lp[H-1]),
                .g(go[H+j]),    .p(po[H+j])
            );
        end
    end else begin : g_pair
        // Reduced-size form: pair, recurse on half, fix the even positions
        logic [H-1:0] yg, yp, zg, zp;

        for (genvar j = 0; j < H; j++) begin : g_pr
            lf_cell u_p (
                .hi_g(gi[2*j+1]), .hi_p(pi[2*j+1]),
                .lo_g(gi[2*j]),   .lo_p(pi[2*j]),
                .g(yg[j]),        .p(yp[j])
            );
        end

        lf_prefix #(.N(H), .K(0)) u_mid (
            .gi(yg), .pi(yp), .go(zg), .po(zp)
        );

        assign go[0] = gi[0];
        assign po[0] = pi[0];

        for (genvar j = 0; j < H; j++) begin : g_odd
            assign go[2*j+1] = zg[j];
            assign po[2*j+1] = zp[j];
        end

        for (genvar j = 1; j < H; j++) begin : g_even
            lf_cell u_f (
                .hi_g(gi[2*j]),  .hi_p(pi[2*j]),
                .lo_g(zg[j-1]),  .lo_p(zp[j-1]),
                .g(go[2*j]),     .p(po[2*j])
            );
        end
    end
endmodule

// File: rtl/lf_adder.sv
module lf_adder #(
    parameter int WIDTH   = 64,
    parameter int OUT_REG = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    localparam int DEPTH = lf_pkg::levels(WIDTH);
    localparam int SW    = WIDTH + 1;

    if (!lf_pkg::width_ok(WIDTH)) begin : g_bad_width
        $error("lf_adder: WIDTH must be a power of two from 4 to 64");
    end

    logic [WIDTH-1:0] gen, prp, hsum;
    logic [WIDTH-1:0] ng, np;
    logic [WIDTH-1:0] cg, cp;
    logic [WIDTH:0]   carry;
    logic [WIDTH-1:0] sum_c;
    logic             cout_c;

    lf_pg #(.WIDTH(WIDTH)) u_pg (
        .a(a), .b(b), .gen(gen), .prp(prp), .hsum(hsum)
    );

    // Seed: fold the carry-in pair (cin, 1) into element 0
    lf_cell u_seed (
        .hi_g(gen[0]), .hi_p(prp[0]),
        .lo_g(cin),    .lo_p(1'b1),
        .g(ng[0]),     .p(np[0])
    );
    assign ng[WIDTH-1:1] = gen[WIDTH-1:1];
    assign np[WIDTH-1:1] = prp[WIDTH-1:1];

    lf_prefix #(.N(WIDTH), .K(0)) u_net (
        .gi(ng), .pi(np), .go(cg), .po(cp)
    );

    assign carry  = {cg, cin};
    assign sum_c  = hsum ^ carry[WIDTH-1:0];
    assign cout_c = carry[WIDTH];

    if (OUT_REG != 0) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sum  <= '0;
                cout <= 1'b0;
            end else begin
                sum  <= sum_c;
                cout <= cout_c;
            end
        end

        // R1
        sum_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> {cout, sum} == ({1'b0, $past(a)} + {1'b0, $past(b)} + SW'($past(cin))));
    end else begin : g_comb
        assign sum  = sum_c;
        assign cout = cout_c;

        // R9
        comb_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
            {cout, sum} == ({1'b0, a} + {1'b0, b} + SW'(cin)));
    end

    // R3
    gp_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gen & ~prp) == '0);

    for (genvar i = 0; i < WIDTH; i++) begin : g_chk
        // R4
        carry_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
            carry[i+1] == (gen[i] | (prp[i] & carry[i])));

        if (i > 0) begin : g_grp
            // R5
            grp_p_chk: assert property (@(posedge clk) disable iff (!rst_n)
                cp[i] == (prp[i] & cp[i-1]));
        end
    end

    // R5
    depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (DEPTH > 0) && (cp[0] == prp[0]));
endmodule

// File: tb/sim_lf_adder.sv
module sim_lf_adder;
    localparam int W0 = 64;
    localparam int W1 = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W0-1:0] a0 = '0, b0 = '0;
    logic          c0 = 1'b0;
    logic [W0-1:0] s0;
    logic          co0;
    logic [W1-1:0] a1 = '0, b1 = '0;
    logic          c1 = 1'b0;
    logic [W1-1:0] s1;
    logic          co1;

    int nchk = 0;
    int nerr = 0;

    logic [W0:0] q_exp[$];
    string       q_tag[$];

    always #10 clk = ~clk;

    lf_adder #(.WIDTH(W0), .OUT_REG(1)) u0 (
        .clk(clk), .rst_n(rst_n), .a(a0), .b(b0), .cin(c0), .sum(s0), .cout(co0)
    );

    lf_adder #(.WIDTH(W1), .OUT_REG(0)) u1 (
        .clk(clk), .rst_n(rst_n), .a(a1), .b(b1), .cin(c1), .sum(s1), .cout(co1)
    );

    task automatic cmp(input string req, input logic [W0:0] act, input logic [W0:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One falling-edge step: check the pending registered result, drive new operands
    task automatic cyc(input logic [W0-1:0] av, input logic [W0-1:0] bv, input logic cv,
                       input string tag, input logic [W1-1:0] a4, input logic [W1-1:0] b4,
                       input logic c4, input string tag4);
        logic [W1:0] e4;
        @(negedge clk);
        if (q_exp.size() > 0) cmp(q_tag.pop_front(), {co0, s0}, q_exp.pop_front());
        a0 = av;
        b0 = bv;
        c0 = cv;
        q_exp.push_back({1'b0, av} + {1'b0, bv} + (W0 + 1)'(cv));
        q_tag.push_back(tag);
        a1 = a4;
        b1 = b4;
        c1 = c4;
        e4 = {1'b0, a4} + {1'b0, b4} + (W1 + 1)'(c4);
        #1;
        cmp(tag4, (W0 + 1)'({co1, s1}), (W0 + 1)'(e4));
    endtask

    function automatic logic [W0-1:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    initial begin
        #(20 * 200000);
        nchk++;
        nerr++;
        $display("FAIL watchdog R1 actual=timeout expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        // R6: operands active during reset must not reach the outputs
        a0 = '1;
        b0 = '1;
        c0 = 1'b1;
        repeat (3) @(negedge clk);
        cmp("R6 sum", (W0 + 1)'(s0), '0);
        cmp("R6 cout", (W0 + 1)'(co0), '0);
        rst_n = 1'b1;

        // R9 exhaustive on the combinational instance, random on the registered one
        for (int i = 0; i < 512; i++) begin
            cyc(rnd64(), rnd64(), 1'($urandom()), "R1 R2 random",
                i[3:0], i[7:4], i[8], "R9 exhaustive");
        end

        // R7 all ones plus one
        cyc('1, 64'd1, 1'b0, "R7", 4'hF, 4'h1, 1'b0, "R7 narrow");
        // R8 carry-in only
        cyc('0, '0, 1'b1, "R8", 4'h0, 4'h0, 1'b1, "R8 narrow");
        // R3 generate everywhere, no propagate-only bits
        cyc('1, '1, 1'b0, "R3", 4'hF, 4'hF, 1'b0, "R3 narrow");
        // R5 full propagate chain driven by cin
        cyc({32{2'b01}}, {32{2'b10}}, 1'b1, "R5", 4'h5, 4'hA, 1'b1, "R5 narrow");
        // R4 mixed generate and kill regions
        cyc(64'hF0F0_0000_FFFF_8001, 64'h0F10_FFFF_0001_7FFF, 1'b0, "R4",
            4'h7, 4'h9, 1'b0, "R4 narrow");
        // R2 carry-out without a full chain
        cyc(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, "R2",
            4'h8, 4'h8, 1'b1, "R2 narrow");
        // flush the last registered result
        cyc('0, '0, 1'b0, "R1 flush", 4'h0, 4'h0, 1'b0, "R9 flush");
        @(negedge clk);
        if (q_exp.size() > 0) cmp(q_tag.pop_front(), {co0, s0}, q_exp.pop_front());

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule